// File: doc/BRIEF.md
# Chained Double-Buffered DMA Channel

This block is one DMA channel. It moves 32-bit words between a peripheral data port and a memory bus. Software programs two address windows through a small register file. The current window is a next-address and limit pair. The continue window is a start and stop pair. When the current window runs out and software has armed the update flag, the engine loads the continue window into the current one by itself. Transfers therefore chain with no idle gap. Software refills the continue window and re-arms the flag while the new current window is moving.

If the flag is not armed when a window ends, the channel shuts down. Each window end, whether it chains or shuts down, sets a completion flag that drives the interrupt line. A saved-limit register records the address at which the window stopped. This includes windows that the peripheral cut short, so software can work out the byte count. Memory accesses use a simple request and acknowledge handshake. An error response sets a sticky bus-exception flag.

Top module: `chain_dma_chan`

## Requirements
- R1: After reset, the status register reads 0, `irq` is low and `mem_req` is low.
- R2: The eight window registers at index 1 to 8 are all writable and read back what was written. The indices are: next 1, limit 2, start 3, stop 4, saved next 5, saved limit 6, saved start 7, saved stop 8.
- R3: A write to the control register (index 0) with the reset command (bit 3) and the init-buffer command (bit 4) leaves the enable, update and complete status bits clear. These are status bits 0, 1 and 2. The write also clears bus-exception (status bit 3) and drops any pending request.
- R4: The set-read command (bit 5) makes status bit 4 read 1, and the set-write command (bit 6) makes it read 0. While status bit 4 is 1, `mem_we` is high, meaning peripheral-to-memory; while it is 0, `mem_we` is low.
- R5: While enabled, the channel requests `mem_addr` equal to the next address. It holds the request until `mem_ack`, then advances next by 4. Successive words go to ascending word addresses.
- R6: When next equals limit and update is set, next and limit are loaded from start and stop. Enable stays set, update clears and complete sets.
- R7: When next equals limit and update is clear, enable clears, complete sets and no further memory request is issued.
- R8: `irq` follows the complete bit. Complete stays set until a clear-complete command (bit 2). A write of clear-complete together with set-update (bit 1) re-arms chaining.
- R9: At every window end, saved limit captures the next address at which the window stopped. A pulse on `per_end` ends the window early, after any access already requested, through the same chain-or-shutdown decision.
- R10: An acknowledged access with `mem_err` high sets the bus-exception bit. The complete and direction bits are left as they were.
- R11: While enable is set, writes to next and limit are ignored. Writes to start and stop are always accepted.
- R12: The end test comes before a request is issued. Enabling with next equal to limit issues no request and completes at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for reads and writes |
| reg_wdata | input | 32 | Register write data, or command bits for index 0 |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write to memory, 0 = read from memory |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Data to memory, taken from the peripheral |
| mem_rdata | input | 32 | Data from memory |
| mem_ack | input | 1 | Access accepted and finished |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| per_rdata | input | 32 | Word supplied by the peripheral |
| per_wdata | output | 32 | Word delivered to the peripheral |
| per_strobe | output | 1 | One word moved this cycle |
| per_end | input | 1 | Peripheral ends the current window early |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions check several properties on every cycle. A pending request holds its address until acknowledged, and each acknowledge steps the next address by one word. No request exists while the channel is disabled. Each window end lands in the chain state or the shutdown state, depending on the update flag. An error response always leaves the bus-exception flag set. A rising interrupt always follows a window end.

Other behaviour is only visible in the bench's scenarios. This covers the exact address sequence across a chained window swap and a re-arm done during a transfer. It also covers the saved-limit values after full and short windows, writes to the current window that are ignored while enabled, and an enable with an empty window.

// File: rtl/chain_dma_pkg.sv
`timescale 1ns/1ps
package chain_dma_pkg;
  // status bit positions (read of index 0)
  localparam int ST_EN   = 0;
  localparam int ST_UPD  = 1;
  localparam int ST_CMPL = 2;
  localparam int ST_BERR = 3;
  localparam int ST_RD   = 4;
  localparam int ST_W    = 5;
  // command bit positions (write of index 0)
  localparam int CM_SET_EN   = 0;
  localparam int CM_SET_UPD  = 1;
  localparam int CM_CLR_CMPL = 2;
  localparam int CM_RST      = 3;
  localparam int CM_INIT     = 4;
  localparam int CM_SET_RD   = 5;
  localparam int CM_SET_WR   = 6;
  localparam int CM_W        = 7;
  // register file layout
  localparam int NWIN = 8;
  localparam logic [3:0] RI_CSR = 4'd0;
  // window slots (register index minus one)
  localparam int W_NEXT   = 0;
  localparam int W_LIMIT  = 1;
  localparam int W_START  = 2;
  localparam int W_STOP   = 3;
  localparam int W_SLIMIT = 5;
endpackage

// File: rtl/chain_dma_regs.sv
`timescale 1ns/1ps
module chain_dma_regs
  import chain_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [DW-1:0]   wdata,
  input  logic            engine_on,
  input  logic            adv,
  input  logic            term,
  input  logic            chain,
  input  logic [ST_W-1:0] status,
  input  logic [3:0]      rd_idx,
  output logic [DW-1:0]   rdata,
  output logic [AW-1:0]   next_addr,
  output logic [AW-1:0]   limit_addr
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic [AW-1:0]   win_q [NWIN];
  logic [AW-1:0]   win_d [NWIN];
  logic [NWIN-1:0] sw_we;

  // software write enables; current-window slots locked while running
  generate
    for (genvar g = 0; g < NWIN; g++) begin : g_we
      localparam bit LOCKABLE = (g == W_NEXT) || (g == W_LIMIT);
      assign sw_we[g] = wr_en && (wr_idx == 4'(g + 1)) && !(LOCKABLE && engine_on);
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NWIN; i++) begin
      win_d[i] = sw_we[i] ? wdata[AW-1:0] : win_q[i];
    end
    if (adv) begin
      win_d[W_NEXT] = win_q[W_NEXT] + STEP;
    end
    if (term) begin
      win_d[W_SLIMIT] = win_q[W_NEXT];
      if (chain) begin
        win_d[W_NEXT]  = win_q[W_START];
        win_d[W_LIMIT] = win_q[W_STOP];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) win_q[i] <= '0;
    end else begin
      for (int i = 0; i < NWIN; i++) win_q[i] <= win_d[i];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_idx == RI_CSR) begin
      rdata[ST_W-1:0] = status;
    end
    for (int i = 0; i < NWIN; i++) begin
      if (rd_idx == 4'(i + 1)) rdata[AW-1:0] = win_q[i];
    end
  end

  assign next_addr  = win_q[W_NEXT];
  assign limit_addr = win_q[W_LIMIT];
endmodule

// File: rtl/chain_dma_seq.sv
`timescale 1ns/1ps
module chain_dma_seq
  import chain_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_wr,
  input  logic [CM_W-1:0] cmd,
  input  logic [AW-1:0]   next_addr,
  input  logic [AW-1:0]   limit_addr,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic            per_end,
  output logic [ST_W-1:0] status,
  output logic            mem_req,
  output logic            adv,
  output logic            term,
  output logic            chain
);
  logic en_q, en_d, upd_q, upd_d, cmpl_q, cmpl_d;
  logic berr_q, berr_d, rd_q, rd_d, req_q, req_d, end_q, end_d;
  logic issue;

  assign term  = en_q && !req_q && ((next_addr == limit_addr) || end_q);
  assign chain = term && upd_q;
  assign issue = en_q && !req_q && !term;
  assign adv   = req_q && mem_ack;

  always_comb begin
    en_d   = en_q;
    upd_d  = upd_q;
    cmpl_d = cmpl_q;
    berr_d = berr_q;
    rd_d   = rd_q;
    req_d  = req_q;
    end_d  = end_q;
    // software clear first so a coincident window end keeps complete
    if (csr_wr && cmd[CM_CLR_CMPL]) cmpl_d = 1'b0;
    if (en_q && per_end) end_d = 1'b1;
    if (adv) begin
      req_d = 1'b0;
      if (mem_err) berr_d = 1'b1;
    end
    if (issue) req_d = 1'b1;
    if (term) begin
      cmpl_d = 1'b1;
      end_d  = 1'b0;
      if (upd_q) upd_d = 1'b0;
      else       en_d  = 1'b0;
    end
    if (csr_wr) begin
      if (cmd[CM_RST]) begin
        en_d   = 1'b0;
        upd_d  = 1'b0;
        cmpl_d = 1'b0;
        berr_d = 1'b0;
        req_d  = 1'b0;
        end_d  = 1'b0;
      end
      if (cmd[CM_INIT]) begin
        req_d = 1'b0;
        end_d = 1'b0;
      end
      if (cmd[CM_SET_UPD]) upd_d = 1'b1;
      if (cmd[CM_SET_EN])  en_d  = 1'b1;
      if (cmd[CM_SET_RD])      rd_d = 1'b1;
      else if (cmd[CM_SET_WR]) rd_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      upd_q  <= 1'b0;
      cmpl_q <= 1'b0;
      berr_q <= 1'b0;
      rd_q   <= 1'b0;
      req_q  <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      upd_q  <= upd_d;
      cmpl_q <= cmpl_d;
      berr_q <= berr_d;
      rd_q   <= rd_d;
      req_q  <= req_d;
      end_q  <= end_d;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_EN]   = en_q;
    status[ST_UPD]  = upd_q;
    status[ST_CMPL] = cmpl_q;
    status[ST_BERR] = berr_q;
    status[ST_RD]   = rd_q;
  end

  assign mem_req = req_q;
endmodule

// File: rtl/chain_dma_chan.sv
`timescale 1ns/1ps
module chain_dma_chan
  import chain_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [DW-1:0] per_rdata,
  output logic [DW-1:0] per_wdata,
  output logic          per_strobe,
  input  logic          per_end,
  output logic          irq
);
  logic            rst_meta_n, rst_sync_n;
  logic            csr_wr;
  logic [ST_W-1:0] status;
  logic [AW-1:0]   cur_next, cur_limit;
  logic            seq_adv, seq_term, seq_chain;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign csr_wr = reg_wr && (reg_addr == RI_CSR);

  chain_dma_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (reg_wr),
    .wr_idx     (reg_addr),
    .wdata      (reg_wdata),
    .engine_on  (status[ST_EN]),
    .adv        (seq_adv),
    .term       (seq_term),
    .chain      (seq_chain),
    .status     (status),
    .rd_idx     (reg_addr),
    .rdata      (reg_rdata),
    .next_addr  (cur_next),
    .limit_addr (cur_limit)
  );

  chain_dma_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .csr_wr     (csr_wr),
    .cmd        (reg_wdata[CM_W-1:0]),
    .next_addr  (cur_next),
    .limit_addr (cur_limit),
    .mem_ack    (mem_ack),
    .mem_err    (mem_err),
    .per_end    (per_end),
    .status     (status),
    .mem_req    (mem_req),
    .adv        (seq_adv),
    .term       (seq_term),
    .chain      (seq_chain)
  );

  assign mem_addr   = cur_next;
  assign mem_we     = status[ST_RD];
  assign mem_wdata  = per_rdata;
  assign per_wdata  = mem_rdata;
  assign per_strobe = seq_adv;
  assign irq        = status[ST_CMPL];
endmodule

// File: rtl/chain_dma_chan_chk.sv
`timescale 1ns/1ps
module chain_dma_chan_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csr_wr,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_err,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] next_addr,
  input logic          en,
  input logic          upd,
  input logic          cmpl,
  input logic          berr,
  input logic          term,
  input logic          irq
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !csr_wr |=> mem_req && $stable(mem_addr)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> next_addr == $past(mem_addr) + STEP); // R5
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !mem_req); // R7
  AST_CHAIN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    term && upd && !csr_wr |=> en && !upd && cmpl); // R6
  AST_SHUTDOWN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    term && !upd && !csr_wr |=> !en && cmpl && !mem_req); // R7
  AST_BUS_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err && !csr_wr |=> berr); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(term)); // R8
endmodule

bind chain_dma_chan chain_dma_chan_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .csr_wr    (csr_wr),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_err   (mem_err),
  .mem_addr  (mem_addr),
  .next_addr (cur_next),
  .en        (status[0]),
  .upd       (status[1]),
  .cmpl      (status[2]),
  .berr      (status[3]),
  .term      (seq_term),
  .irq       (irq)
);

// File: tb/chain_dma_chan_bench.sv
`timescale 1ns/1ps
module chain_dma_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] per_rdata, per_wdata;
  logic        per_strobe, per_end, irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] log_addr [64];
  logic        log_we   [64];
  int          nlog = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;

  always #2.5 clk = ~clk;

  chain_dma_chan u_chain_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .per_rdata(per_rdata), .per_wdata(per_wdata), .per_strobe(per_strobe),
    .per_end(per_end), .irq(irq)
  );

  // memory responder: one-cycle acknowledge, logs each access
  initial begin
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack   = 1'b1;
        mem_err   = (mem_addr == err_addr);
        mem_rdata = mem_addr ^ 32'h5A5A_0000;
        if (nlog < 64) begin
          log_addr[nlog] = mem_addr;
          log_we[nlog]   = mem_we;
        end
        nlog++;
      end else begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 500; i++) begin
      rd(4'd0, s);
      if (!s[0]) break;
    end
  endtask

  // register index and value written, read back unchanged (R2)
  localparam logic [35:0] VEC [8] = '{
    {4'd1, 32'h0000_1000}, {4'd2, 32'h0000_2004}, {4'd3, 32'h1234_5678},
    {4'd4, 32'h8765_4320}, {4'd5, 32'hA5A5_A5A4}, {4'd6, 32'h0F0F_0F00},
    {4'd7, 32'hFFFF_FFFC}, {4'd8, 32'h0000_0004}
  };

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int nb;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    per_rdata = 32'hC0DE_0000; per_end = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(4'd0, s);
    chk("R1 status", s, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'h0);

    // R2 vector walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][35:32], VEC[i][31:0]);
      rd(VEC[i][35:32], s);
      chk("R2 readback", s, VEC[i][31:0]);
    end

    // R4 direction bit
    wr(4'd0, 32'h20);
    rd(4'd0, s);
    chk("R4 set-read status", s & 32'h10, 32'h10);
    chk("R4 mem_we read", {31'b0, mem_we}, 32'h1);
    wr(4'd0, 32'h40);
    rd(4'd0, s);
    chk("R4 set-write status", s & 32'h10, 32'h0);

    // R3 reset with init-buffer
    wr(4'd0, 32'h02);
    wr(4'd0, 32'h18);
    rd(4'd0, s);
    chk("R3 flags clear", s & 32'h7, 32'h0);

    // R5/R7/R9 single window ending in shutdown
    nb = nlog;
    wr(4'd1, 32'h100);
    wr(4'd2, 32'h110);
    wr(4'd0, 32'h41);
    wait_idle();
    chk("R5 access count", nlog - nb, 4);
    for (int i = 0; i < 4; i++)
      chk("R5 address order", log_addr[nb + i], 32'h100 + 32'(4 * i));
    chk("R4 mem_we write", {31'b0, log_we[nb]}, 32'h0);
    rd(4'd0, s);
    chk("R7 shutdown status", s, 32'h04);
    chk("R8 irq set", {31'b0, irq}, 32'h1);
    rd(4'd6, s);
    chk("R9 saved limit full", s, 32'h110);
    nb = nlog;
    repeat (6) @(negedge clk);
    chk("R7 no further requests", nlog - nb, 0);
    wr(4'd0, 32'h04);
    chk("R8 irq cleared", {31'b0, irq}, 32'h0);

    // R6/R8/R11 chain with re-arm during transfer
    wr(4'd0, 32'h18);
    nb = nlog;
    wr(4'd1, 32'h200);
    wr(4'd2, 32'h208);
    wr(4'd3, 32'h300);
    wr(4'd4, 32'h340);
    wr(4'd0, 32'h23);
    for (int i = 0; i < 200; i++) begin
      rd(4'd0, s);
      if (s[2]) break;
    end
    chk("R6 chained status", s, 32'h15);
    rd(4'd2, s);
    chk("R6 limit from stop", s, 32'h340);
    wr(4'd3, 32'h400);
    wr(4'd4, 32'h404);
    wr(4'd2, 32'h999);
    wr(4'd0, 32'h06);
    rd(4'd0, s);
    chk("R8 re-armed status", s, 32'h13);
    chk("R8 irq low after clear", {31'b0, irq}, 32'h0);
    rd(4'd2, s);
    chk("R11 limit write ignored", s, 32'h340);
    rd(4'd3, s);
    chk("R11 start write accepted", s, 32'h400);
    wait_idle();
    chk("R6 chained access count", nlog - nb, 19);
    chk("R6 first of second window", log_addr[nb + 2], 32'h300);
    chk("R6 last of second window", log_addr[nb + 17], 32'h33C);
    chk("R6 third window", log_addr[nb + 18], 32'h400);
    chk("R4 mem_we follows read", {31'b0, log_we[nb + 5]}, 32'h1);
    rd(4'd0, s);
    chk("R7 final status", s, 32'h14);
    rd(4'd6, s);
    chk("R9 saved limit after chain", s, 32'h404);

    // R9 peripheral ends the window early
    wr(4'd0, 32'h18);
    nb = nlog;
    wr(4'd1, 32'h500);
    wr(4'd2, 32'h600);
    wr(4'd0, 32'h41);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (nlog - nb >= 3) break;
    end
    per_end = 1'b1;
    @(negedge clk);
    per_end = 1'b0;
    wait_idle();
    rd(4'd6, s);
    chk("R9 saved limit short", s, 32'h500 + 32'(4 * (nlog - nb)));
    rd(4'd1, s);
    chk("R9 next equals saved", s, 32'h500 + 32'(4 * (nlog - nb)));
    chk("R9 stopped early", {31'b0, (nlog - nb) < 10}, 32'h1);

    // R10 bus error
    wr(4'd0, 32'h18);
    err_addr = 32'h704;
    wr(4'd1, 32'h700);
    wr(4'd2, 32'h708);
    wr(4'd0, 32'h41);
    wait_idle();
    rd(4'd0, s);
    chk("R10 bus exception with complete", s, 32'h0C);
    err_addr = 32'hFFFF_FFFF;
    wr(4'd0, 32'h18);
    rd(4'd0, s);
    chk("R3 reset clears exception", s, 32'h0);

    // R12 empty window
    nb = nlog;
    wr(4'd1, 32'h800);
    wr(4'd2, 32'h800);
    wr(4'd0, 32'h41);
    repeat (5) @(negedge clk);
    chk("R12 no request", nlog - nb, 0);
    rd(4'd0, s);
    chk("R12 completes at once", s, 32'h04);
    rd(4'd6, s);
    chk("R12 saved limit", s, 32'h800);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule